// File: doc/BRIEF.md
# Character Display Command Engine

This block is the command interpreter of a controller for a character display of two lines of forty cells. It takes one byte at a time from an upstream stream: either a command (register select low) or a data byte (register select high), with a separate read flag for data reads. It keeps one address counter that points either into the display data memory or into a 64-byte user-pattern memory. It also holds the entry mode, the horizontal view offset, the display, cursor and blink flags, the bus-width flag and the brightness level. Both memories sit outside the block. The engine drives their write ports and read ports directly.

Every command finishes in the cycle it is accepted, except clear. Clear sweeps the space character across all eighty display cells, one cell per cycle, and holds the busy flag while it does so. The upstream port is valid/ready. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a clear is in progress, and the source must then hold its byte until it is accepted. The status byte carries the busy flag above the address counter and can be read at any time.

Top module: `chardisp_cmd_engine`

## Requirements
- R1: After reset: display, cursor and blink off, bus_8bit high, bright = 00, shift_ofs = 0, status = 00h (counter at display address 0, not busy), in_ready high.
- R2: Command 01h writes 20h to all eighty display addresses (00h–27h and 40h–67h), one per cycle. Busy is high for exactly 80 cycles after acceptance and in_ready is low meanwhile. At the end the counter is 0 and points at display memory, shift_ofs is 0 and increment mode is forced.
- R3: Commands 02h and 03h set the counter to 0, point it at display memory and set shift_ofs to 0, without any memory write.
- R4: Command 0000_01IS sets the step direction (I=1 up, I=0 down) used after each memory access. In display memory, up steps 27h to 40h and 67h to 00h, and down steps 00h to 67h and 40h to 27h.
- R5: With S=1 a display-memory data write steps the counter and also moves the view: shift_ofs +1 when I=1 and -1 when I=0, modulo 40. Reads never change shift_ofs.
- R6: Command 0001_SR00 touches no memory. S=0 steps the counter (R=1 up, R=0 down). S=1 leaves the counter and changes shift_ofs by -1 for R=1 or +1 for R=0, modulo 40.
- R7: Command 01aa_aaaa loads a 6-bit pattern address. Pattern accesses then wrap between 3Fh and 00h and never change shift_ofs.
- R8: Command 1aaa_aaaa loads the 7-bit display address aaa_aaaa and points the counter at display memory.
- R9: A data write that immediately follows command 001F_xxxx sets bright from its bits 1:0 (00 = 100%, 01 = 75%, 10 = 50%, 11 = 25%), writes no memory and leaves the counter unchanged. A command in that slot cancels the capture.
- R10: Command 0000_1DCB sets disp_on = D, cursor_on = C and blink_on = B.
- R11: status is {busy, counter} with busy in bit 7. While busy, no data access reaches either memory.
- R12: In command 001F_xxxx, bit F sets bus_8bit.
- R13: A data read (in_rs=1, in_rd=1) pulses the read enable of the addressed memory for one cycle, with the current counter as address, and then steps the counter. A status read (in_rs=0, in_rd=1) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Engine can take a byte (low during clear) |
| in_rs | input | 1 | 1 = data access, 0 = command |
| in_rd | input | 1 | 1 = read access |
| in_byte | input | 8 | Command or data byte |
| dd_we | output | 1 | Display memory write enable |
| dd_waddr | output | 7 | Display memory write address |
| dd_wdata | output | 8 | Display memory write data |
| dd_re | output | 1 | Display memory read enable |
| dd_raddr | output | 7 | Display memory read address |
| cg_we | output | 1 | Pattern memory write enable |
| cg_waddr | output | 6 | Pattern memory write address |
| cg_wdata | output | 8 | Pattern memory write data |
| cg_re | output | 1 | Pattern memory read enable |
| cg_raddr | output | 6 | Pattern memory read address |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor cell blinks |
| bus_8bit | output | 1 | 1 = byte-wide host bus, 0 = nibble bus |
| bright | output | 2 | Brightness code |
| shift_ofs | output | 6 | View offset, 0 to 39 |
| status | output | 8 | Busy flag and address counter |

## Verification
The bench targets the line seams of the counter: 27h to 40h, 67h to 00h and their reverse. A stepper that wraps naively would land in the unused 28h–3Fh hole or go past 67h. It checks that the view offset wraps from 0 to 39 and that shift direction follows the entry mode. Swapped signs there would move the view the same way as the cursor. It checks that a data byte after the width command changes only brightness, and that an intervening command cancels this. A design that fails this would corrupt display memory or keep a stale capture armed. It also counts the cycles of busy during clear and checks every cell and the forced increment afterwards, so a short sweep or a left-over decrement mode shows up.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL, OP_SHIFT,
    OP_FUNC, OP_CGADDR, OP_DDADDR, OP_WRITE, OP_READ
  } op_e;
endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
  import chardisp_pkg::*;
(
  input  logic       rs,
  input  logic       rd,
  input  logic [7:0] code,
  output op_e        op
);
  // highest set bit of a command byte selects the command
  always_comb begin
    if (rs)           op = rd ? OP_READ : OP_WRITE;
    else if (rd)      op = OP_NOP;
    else if (code[7]) op = OP_DDADDR;
    else if (code[6]) op = OP_CGADDR;
    else if (code[5]) op = OP_FUNC;
    else if (code[4]) op = OP_SHIFT;
    else if (code[3]) op = OP_DISPCTL;
    else if (code[2]) op = OP_ENTRY;
    else if (code[1]) op = OP_HOME;
    else if (code[0]) op = OP_CLEAR;
    else              op = OP_NOP;
  end
endmodule

// File: rtl/chardisp_addr_step.sv
module chardisp_addr_step #(
  parameter int AW       = 7,
  parameter int CGW      = 6,
  parameter int LINE_LEN = 40,
  parameter int LINE2    = 64
) (
  input  logic [AW-1:0] cur,
  input  logic          is_cg,
  input  logic          up,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] L1_END   = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_START = AW'(LINE2);
  localparam logic [AW-1:0] L2_END   = AW'(LINE2 + LINE_LEN - 1);

  logic [CGW-1:0] cg_nxt;
  assign cg_nxt = up ? cur[CGW-1:0] + 1'b1 : cur[CGW-1:0] - 1'b1;

  always_comb begin
    if (is_cg)            nxt = AW'(cg_nxt);
    else if (up)          nxt = (cur == L1_END) ? L2_START :
                                (cur == L2_END) ? '0 : cur + 1'b1;
    else                  nxt = (cur == '0) ? L2_END :
                                (cur == L2_START) ? L1_END : cur - 1'b1;
  end
endmodule

// File: rtl/chardisp_fill.sv
module chardisp_fill #(
  parameter int AW       = 7,
  parameter int LINE_LEN = 40,
  parameter int LINE2    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] nxt;

  chardisp_addr_step #(.AW(AW), .CGW(AW - 1), .LINE_LEN(LINE_LEN), .LINE2(LINE2)) u_step (
    .cur(addr), .is_cg(1'b0), .up(1'b1), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      addr <= nxt;
      if (nxt == '0) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/chardisp_cmd_engine.sv
module chardisp_cmd_engine
  import chardisp_pkg::*;
#(
  parameter int          AW        = 7,
  parameter int          CGW       = 6,
  parameter int          LINE_LEN  = 40,
  parameter int          LINE2     = 64,
  parameter logic [7:0]  FILL_CHAR = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_rs,
  input  logic          in_rd,
  input  logic [7:0]    in_byte,
  output logic          dd_we,
  output logic [AW-1:0] dd_waddr,
  output logic [7:0]    dd_wdata,
  output logic          dd_re,
  output logic [AW-1:0] dd_raddr,
  output logic          cg_we,
  output logic [CGW-1:0] cg_waddr,
  output logic [7:0]    cg_wdata,
  output logic          cg_re,
  output logic [CGW-1:0] cg_raddr,
  output logic          disp_on,
  output logic          cursor_on,
  output logic          blink_on,
  output logic          bus_8bit,
  output logic [1:0]    bright,
  output logic [$clog2(LINE_LEN)-1:0] shift_ofs,
  output logic [AW:0]   status
);
  localparam int SW = $clog2(LINE_LEN);
  localparam logic [SW-1:0] OFS_MAX = SW'(LINE_LEN - 1);

  op_e           op;
  logic          fire, fill_busy, fill_start, step_up, access;
  logic [AW-1:0] fill_addr, ac_q, ac_nxt;
  logic          cg_sel_q, inc_q, sft_q, arm_q;
  logic [SW-1:0] ofs_q, ofs_plus, ofs_minus;

  chardisp_decode u_dec (.rs(in_rs), .rd(in_rd), .code(in_byte), .op(op));

  chardisp_addr_step #(.AW(AW), .CGW(CGW), .LINE_LEN(LINE_LEN), .LINE2(LINE2)) u_step (
    .cur(ac_q), .is_cg(cg_sel_q), .up(step_up), .nxt(ac_nxt)
  );

  chardisp_fill #(.AW(AW), .LINE_LEN(LINE_LEN), .LINE2(LINE2)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(fill_start), .busy(fill_busy), .addr(fill_addr)
  );

  assign in_ready   = !fill_busy;
  assign fire       = in_valid && in_ready;
  assign fill_start = fire && (op == OP_CLEAR);
  assign step_up    = (op == OP_SHIFT) ? in_byte[2] : inc_q;
  assign access     = fire && !arm_q && (op == OP_WRITE);
  assign ofs_plus   = (ofs_q == OFS_MAX) ? '0 : ofs_q + 1'b1;
  assign ofs_minus  = (ofs_q == '0) ? OFS_MAX : ofs_q - 1'b1;

  // memory ports: the clear sweep owns the display write port while busy
  assign dd_we    = fill_busy || (access && !cg_sel_q);
  assign dd_waddr = fill_busy ? fill_addr : ac_q;
  assign dd_wdata = fill_busy ? FILL_CHAR : in_byte;
  assign cg_we    = access && cg_sel_q;
  assign cg_waddr = ac_q[CGW-1:0];
  assign cg_wdata = in_byte;
  assign dd_re    = fire && (op == OP_READ) && !cg_sel_q;
  assign dd_raddr = ac_q;
  assign cg_re    = fire && (op == OP_READ) && cg_sel_q;
  assign cg_raddr = ac_q[CGW-1:0];

  assign shift_ofs = ofs_q;
  assign status    = {fill_busy, ac_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q <= '0; cg_sel_q <= 1'b0; inc_q <= 1'b1; sft_q <= 1'b0;
      arm_q <= 1'b0; ofs_q <= '0; disp_on <= 1'b0; cursor_on <= 1'b0;
      blink_on <= 1'b0; bus_8bit <= 1'b1; bright <= 2'b00;
    end else if (fire) begin
      if (op != OP_NOP) arm_q <= (op == OP_FUNC);
      unique case (op)
        OP_CLEAR: begin
          ac_q <= '0; cg_sel_q <= 1'b0; ofs_q <= '0; inc_q <= 1'b1;
        end
        OP_HOME: begin
          ac_q <= '0; cg_sel_q <= 1'b0; ofs_q <= '0;
        end
        OP_ENTRY:   begin inc_q <= in_byte[1]; sft_q <= in_byte[0]; end
        OP_DISPCTL: begin
          disp_on <= in_byte[2]; cursor_on <= in_byte[1]; blink_on <= in_byte[0];
        end
        OP_SHIFT: begin
          if (in_byte[3]) ofs_q <= in_byte[2] ? ofs_minus : ofs_plus;
          else            ac_q  <= ac_nxt;
        end
        OP_FUNC:   bus_8bit <= in_byte[4];
        OP_CGADDR: begin ac_q <= AW'(in_byte[CGW-1:0]); cg_sel_q <= 1'b1; end
        OP_DDADDR: begin ac_q <= in_byte[AW-1:0]; cg_sel_q <= 1'b0; end
        OP_WRITE: begin
          if (arm_q) bright <= in_byte[1:0];
          else begin
            ac_q <= ac_nxt;
            if (!cg_sel_q && sft_q) ofs_q <= inc_q ? ofs_plus : ofs_minus;
          end
        end
        OP_READ: ac_q <= ac_nxt;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chardisp_cmd_engine_chk.sv
module chardisp_cmd_engine_chk #(
  parameter int         LINE_LEN  = 40,
  parameter logic [7:0] FILL_CHAR = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_rs,
  input logic       in_rd,
  input logic [7:0] in_byte,
  input logic       dd_we,
  input logic [7:0] dd_wdata,
  input logic       dd_re,
  input logic       cg_we,
  input logic       cg_re,
  input logic [1:0] bright,
  input logic [$clog2(LINE_LEN)-1:0] shift_ofs,
  input logic [7:0] status,
  input logic       cg_sel
);
  a_r2_fill_char: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && dd_we) |-> (dd_wdata == FILL_CHAR));

  a_r2_end_home: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> (status[6:0] == 7'd0 && shift_ofs == '0));

  a_r3_home: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_rs && !in_rd && in_byte[7:1] == 7'd1)
      |=> (status[6:0] == 7'd0 && shift_ofs == '0));

  a_r5_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(shift_ofs) < LINE_LEN);

  a_r7_cg_range: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> !status[6]);

  a_r9_no_write_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bright) |-> $past(!dd_we && !cg_we));

  a_r11_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !(cg_we || cg_re || dd_re));
endmodule

bind chardisp_cmd_engine chardisp_cmd_engine_chk #(.LINE_LEN(LINE_LEN), .FILL_CHAR(FILL_CHAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_rs(in_rs),
  .in_rd(in_rd), .in_byte(in_byte), .dd_we(dd_we), .dd_wdata(dd_wdata), .dd_re(dd_re),
  .cg_we(cg_we), .cg_re(cg_re), .bright(bright), .shift_ofs(shift_ofs),
  .status(status), .cg_sel(cg_sel_q)
);

// File: tb/sim_chardisp_cmd_engine.sv
module sim_chardisp_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_rs = 1'b0, in_rd = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, dd_we, dd_re, cg_we, cg_re;
  logic [6:0] dd_waddr, dd_raddr;
  logic [7:0] dd_wdata, cg_wdata, status;
  logic [5:0] cg_waddr, cg_raddr, shift_ofs;
  logic disp_on, cursor_on, blink_on, bus_8bit;
  logic [1:0] bright;

  int checks = 0, errors = 0, dd_writes = 0;
  logic [7:0] ddm [128];
  logic [7:0] cgm [64];
  logic cap_dd_re, cap_cg_re;
  logic [6:0] cap_dd_raddr;
  logic [5:0] cap_cg_raddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  chardisp_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_rs(in_rs),
    .in_rd(in_rd), .in_byte(in_byte), .dd_we(dd_we), .dd_waddr(dd_waddr),
    .dd_wdata(dd_wdata), .dd_re(dd_re), .dd_raddr(dd_raddr), .cg_we(cg_we),
    .cg_waddr(cg_waddr), .cg_wdata(cg_wdata), .cg_re(cg_re), .cg_raddr(cg_raddr),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .bus_8bit(bus_8bit),
    .bright(bright), .shift_ofs(shift_ofs), .status(status)
  );

  always @(posedge clk) begin
    if (rst_n && dd_we) begin ddm[dd_waddr] <= dd_wdata; dd_writes <= dd_writes + 1; end
    if (rst_n && cg_we) cgm[cg_waddr] <= cg_wdata;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic rs, input logic rd, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_rs = rs; in_rd = rd; in_byte = b;
    while (!in_ready) @(negedge clk);
    #1;
    cap_dd_re = dd_re; cap_dd_raddr = dd_raddr; cap_cg_re = cg_re; cap_cg_raddr = cg_raddr;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); send(1'b0, 1'b0, b); endtask
  task automatic wr(input logic [7:0] b);  send(1'b1, 1'b0, b); endtask
  task automatic rd_data();                send(1'b1, 1'b1, 8'h00); endtask

  task automatic t_reset();
    check("R1 status", status, 8'h00);
    check("R1 flags", {disp_on, cursor_on, blink_on, bus_8bit}, 4'b0001);
    check("R1 bright", bright, 0);
    check("R1 shift", shift_ofs, 0);
    check("R1 ready", in_ready, 1);
  endtask

  task automatic t_dispctl();
    cmd(8'h0F); check("R10 on all", {disp_on, cursor_on, blink_on}, 3'b111);
    cmd(8'h0C); check("R10 display only", {disp_on, cursor_on, blink_on}, 3'b100);
  endtask

  task automatic t_bright();
    int w0;
    cmd(8'h20); check("R12 nibble bus", bus_8bit, 0);
    w0 = dd_writes;
    wr(8'hF2);
    check("R9 capture", bright, 2);
    check("R9 no mem write", dd_writes, w0);
    check("R9 counter held", status, 8'h00);
    cmd(8'h30); check("R12 byte bus", bus_8bit, 1);
    cmd(8'h0C);
    wr(8'h03);
    check("R9 cancelled", bright, 2);
    check("R9 written instead", ddm[0], 8'h03);
    check("R9 counter stepped", status, 8'h01);
  endtask

  task automatic t_wrap();
    cmd(8'hA7); check("R8 load line1 end", status, 8'h27);
    wr(8'h41); check("R4 wrote 27h", ddm[7'h27], 8'h41);
    check("R4 27h->40h", status, 8'h40);
    cmd(8'hE7); wr(8'h42); check("R4 67h->00h", status, 8'h00);
    cmd(8'h04); wr(8'h43); check("R4 down 00h->67h", status, 8'h67);
    cmd(8'hC0); wr(8'h44); check("R4 down 40h->27h", status, 8'h27);
    cmd(8'h06);
  endtask

  task automatic t_view_shift();
    cmd(8'h02); cmd(8'h07);
    wr(8'h50); wr(8'h51);
    check("R5 counter up", status, 8'h02); check("R5 view up", shift_ofs, 2);
    cmd(8'h05); wr(8'h52);
    check("R5 counter down", status, 8'h01); check("R5 view down", shift_ofs, 1);
    rd_data();
    check("R13 dd read port", {cap_dd_re, cap_cg_re, cap_dd_raddr}, {2'b10, 7'h01});
    check("R5 read no shift", shift_ofs, 1);
    check("R13 read steps", status, 8'h00);
    cmd(8'h02); wr(8'h53);
    check("R5 view wraps 0->39", shift_ofs, 39);
    send(1'b0, 1'b1, 8'hFF);
    check("R13 status read no change", {status, 2'b00, shift_ofs}, {8'h67, 8'd39});
    cmd(8'h06);
  endtask

  task automatic t_shift_cmd();
    cmd(8'h02);
    cmd(8'h14); check("R6 cursor right", {status, 2'b00, shift_ofs}, {8'h01, 8'd0});
    cmd(8'h10); check("R6 cursor left", status, 8'h00);
    cmd(8'h1C); check("R6 view right", {status, 2'b00, shift_ofs}, {8'h00, 8'd39});
    cmd(8'h18); check("R6 view left", shift_ofs, 0);
  endtask

  task automatic t_home();
    cmd(8'hC5); wr(8'h61); cmd(8'h18);
    cmd(8'h03);
    check("R3 home counter", status, 8'h00);
    check("R3 home view", shift_ofs, 0);
    check("R3 ram kept", ddm[7'h45], 8'h61);
  endtask

  task automatic t_pattern();
    cmd(8'h7F); check("R7 load", status, 8'h3F);
    wr(8'hAA); check("R7 written", cgm[6'h3F], 8'hAA);
    check("R7 3Fh->00h", status, 8'h00);
    cmd(8'h05); wr(8'hBB);
    check("R7 00h->3Fh", status, 8'h3F);
    check("R7 no view shift", shift_ofs, 0);
    rd_data();
    check("R13 cg read port", {cap_dd_re, cap_cg_re, 1'b0, cap_cg_raddr}, {2'b01, 7'h3F});
    cmd(8'h06);
  endtask

  task automatic t_clear();
    int n, bad;
    cmd(8'h80); wr(8'h11); cmd(8'hE0); wr(8'h22); cmd(8'h1C); cmd(8'h04);
    cmd(8'h01);
    check("R11 busy flag", status[7], 1);
    check("R2 not ready", in_ready, 0);
    n = 0;
    while (status[7] && n < 200) begin @(posedge clk); #1; n++; end
    check("R2 busy cycles", n, 80);
    bad = 0;
    for (int a = 0; a < 128; a++)
      if ((a < 40 || (a >= 64 && a < 104)) && ddm[a] !== 8'h20) bad++;
    check("R2 all cells blank", bad, 0);
    check("R2 end state", {status, 2'b00, shift_ofs}, {8'h00, 8'd0});
    wr(8'h31); check("R2 increment forced", status, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dispctl();
    t_bright();
    t_wrap();
    t_view_shift();
    t_shift_cmd();
    t_home();
    t_pattern();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule